// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block remembers, for recently taken branches, the first two instructions found at the branch target. The fetch unit presents a branch address on the lookup port. On a hit, the block returns the two target instructions one cycle later, ready to go straight into the instruction queue. A loop that branches back to the same place therefore runs without a fetch bubble. After a taken branch resolves, the fetch logic writes the branch address and the fetched target pair through the fill port.

Storage is set associative with four ways per set. The set index comes from the word-address bits just above the byte offset, and the remaining upper bits form the tag. Replacement inside each set is a three-bit tree pseudo-LRU. An empty way is always used before any valid way is evicted. A fill whose tag is already present rewrites that way in place. Two control inputs complete the interface: one suppresses every hit, and one discards all entries in a single cycle.

Top module: `brtgt_cache`

## Requirements
- R1: When `lk_valid_i` is high, `enable_i` is high and a valid entry in the addressed set holds the lookup tag, `hit_o` is 1 on the cycle after the lookup, and `hit_insn0_o`/`hit_insn1_o` carry that entry's first and second target instructions.
- R2: The set index is lookup/fill address bits [IDX_W+1:2], with IDX_W = log2(SETS). The tag is bits [ADDR_W-1:IDX_W+2]. Address bits [1:0] never affect a result.
- R3: `hit_o` is 1 only in the cycle after a lookup request. Whenever `hit_o` is 0, both instruction outputs are all zeros.
- R4: While `enable_i` is low, no hit is reported. Stored entries are kept and hit again once `enable_i` returns high.
- R5: `inv_all_i` makes every entry invalid in one cycle. A lookup presented in that same cycle misses.
- R6: A fill requested in the same cycle as `inv_all_i` is discarded.
- R7: A fill whose tag is already valid in its set overwrites that way's instructions, so no tag is ever held twice in one set.
- R8: A fill with a new tag goes to the lowest-numbered invalid way of its set, if the set has one.
- R9: When a set is full, a new tag evicts the pseudo-LRU victim. The per-set bits are: root (0 = victim among ways 0/1, 1 = among ways 2/3), left (0 = way 0, 1 = way 1) and right (0 = way 2, 1 = way 3). A fill or a lookup hit on way w sets the bits to point away from w. A fill takes precedence over a hit in the same set in the same cycle. Invalidate leaves these bits unchanged.
- R10: All SETS x 4 entries can be valid at once, and each is returned intact.
- R11: After reset, all entries are invalid, all pseudo-LRU bits are zero and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | High allows hits to be reported |
| inv_all_i | input | 1 | Invalidate every entry this cycle |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | ADDR_W | Branch address to look up |
| fill_valid_i | input | 1 | Fill request |
| fill_addr_i | input | ADDR_W | Branch address being filled |
| fill_insn0_i | input | INSN_W | First target instruction to store |
| fill_insn1_i | input | INSN_W | Second target instruction to store |
| hit_o | output | 1 | Registered hit flag for the previous lookup |
| hit_insn0_o | output | INSN_W | First target instruction on a hit, else zero |
| hit_insn1_o | output | INSN_W | Second target instruction on a hit, else zero |

## Verification
The bench instantiates the block with SETS=4, ADDR_W=12 and INSN_W=16. This gives an 8-bit tag and only 16 entries in total. With that configuration, directed steps can fill every entry, force an eviction in a full set, and drive invalidates colliding with fills and lookups. A few thousand cycles drawn from a pool of six tags per set then drive every set repeatedly through fill, hit, eviction and flush. A bench model, which keeps the pseudo-LRU as separate root/left/right flags, predicts each output cycle by cycle.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

  localparam int NWAYS = 4;

  // bit0 = root, bit1 = left pair selector, bit2 = right pair selector
  typedef logic [2:0] plru_t;
  typedef logic [NWAYS-1:0] way_vec_t;
  typedef logic [1:0] way_idx_t;

  function automatic way_idx_t plru_victim(input plru_t p);
    if (p[0]) return {1'b1, p[2]};
    return {1'b0, p[1]};
  endfunction

  function automatic plru_t plru_touch(input plru_t p, input way_idx_t w);
    plru_t n;
    n = p;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  function automatic way_idx_t way_enc(input way_vec_t oh);
    way_idx_t r;
    r = '0;
    for (int i = 0; i < NWAYS; i++)
      if (oh[i]) r = way_idx_t'(i);
    return r;
  endfunction

  function automatic way_vec_t way_dec(input way_idx_t w);
    return way_vec_t'(1) << w;
  endfunction

  function automatic way_idx_t first_free(input way_vec_t valid);
    way_idx_t r;
    r = '0;
    for (int i = NWAYS - 1; i >= 0; i--)
      if (!valid[i]) r = way_idx_t'(i);
    return r;
  endfunction

endpackage

// File: rtl/brtgt_way.sv
module brtgt_way #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 26,
  parameter int INSN_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [INSN_W-1:0] wr_insn0_i,
  input  logic [INSN_W-1:0] wr_insn1_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic              ra_valid_o,
  output logic [TAG_W-1:0]  ra_tag_o,
  output logic [INSN_W-1:0] ra_insn0_o,
  output logic [INSN_W-1:0] ra_insn1_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic              rb_valid_o,
  output logic [TAG_W-1:0]  rb_tag_o,
  output logic              any_valid_o
);

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q   [SETS];
  logic [INSN_W-1:0] insn0_q [SETS];
  logic [INSN_W-1:0] insn1_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         valid_q <= '0;
    else if (clear_i)    valid_q <= '0;
    else if (wr_en_i)    valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]   <= wr_tag_i;
      insn0_q[wr_idx_i] <= wr_insn0_i;
      insn1_q[wr_idx_i] <= wr_insn1_i;
    end
  end

  assign ra_valid_o  = valid_q[ra_idx_i];
  assign ra_tag_o    = tag_q[ra_idx_i];
  assign ra_insn0_o  = insn0_q[ra_idx_i];
  assign ra_insn1_o  = insn1_q[ra_idx_i];
  assign rb_valid_o  = valid_q[rb_idx_i];
  assign rb_tag_o    = tag_q[rb_idx_i];
  assign any_valid_o = |valid_q;

  // R5: a clear leaves nothing valid in the next cycle
  p_clear_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (valid_q == '0));

  // R8/R10: a write always leaves its slot valid
  p_write_sets_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clear_i) |=> valid_q[$past(wr_idx_i)]);

endmodule

// File: rtl/brtgt_repl.sv
module brtgt_repl
  import brtgt_pkg::*;
#(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  way_vec_t         fill_valid_i,
  input  way_vec_t         fill_match_i,
  output way_vec_t         fill_way_o,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  way_idx_t         touch_way_i
);

  plru_t    plru_q [SETS];
  way_idx_t fill_way_idx_w;
  logic     set_full_w;
  logic     tag_present_w;

  assign set_full_w    = &fill_valid_i;
  assign tag_present_w = |fill_match_i;

  always_comb begin
    if (tag_present_w)   fill_way_o = fill_match_i;
    else if (!set_full_w) fill_way_o = way_dec(first_free(fill_valid_i));
    else                 fill_way_o = way_dec(plru_victim(plru_q[fill_idx_i]));
  end

  assign fill_way_idx_w = way_enc(fill_way_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (fill_en_i && fill_idx_i == IDX_W'(s))
          plru_q[s] <= plru_touch(plru_q[s], fill_way_idx_w);
        else if (touch_en_i && touch_idx_i == IDX_W'(s))
          plru_q[s] <= plru_touch(plru_q[s], touch_way_i);
      end
    end
  end

  // R7: exactly one way is written per fill
  p_fill_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> $onehot(fill_way_o));

  // R8: a set with room never loses a valid entry to a new tag
  p_free_way_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !tag_present_w && !set_full_w) |-> ((fill_way_o & fill_valid_i) == '0));

  // R9: the way just filled is not the next victim of its set
  p_plru_moves_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> (plru_victim(plru_q[$past(fill_idx_i)]) != $past(fill_way_idx_w)));

endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache
  import brtgt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int SETS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              inv_all_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [INSN_W-1:0] fill_insn0_i,
  input  logic [INSN_W-1:0] fill_insn1_i,
  output logic              hit_o,
  output logic [INSN_W-1:0] hit_insn0_o,
  output logic [INSN_W-1:0] hit_insn1_o
);

  localparam int OFS_W = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic [IDX_W-1:0]  lk_idx_w, fill_idx_w;
  logic [TAG_W-1:0]  lk_tag_w, fill_tag_w;
  way_vec_t          ra_valid_w, rb_valid_w, any_valid_vec_w;
  logic [TAG_W-1:0]  ra_tag_w   [NWAYS];
  logic [TAG_W-1:0]  rb_tag_w   [NWAYS];
  logic [INSN_W-1:0] ra_insn0_w [NWAYS];
  logic [INSN_W-1:0] ra_insn1_w [NWAYS];
  way_vec_t          lk_match_w, fill_match_w, fill_way_w;
  logic              lk_hit_w, fill_we_w, any_valid_w;
  logic [INSN_W-1:0] sel_insn0_w, sel_insn1_w;
  logic              unused_lowbits_w;

  assign lk_idx_w   = set_of(lk_addr_i);
  assign lk_tag_w   = tag_of(lk_addr_i);
  assign fill_idx_w = set_of(fill_addr_i);
  assign fill_tag_w = tag_of(fill_addr_i);
  assign unused_lowbits_w = ^{lk_addr_i[OFS_W-1:0], fill_addr_i[OFS_W-1:0]};

  assign fill_we_w = fill_valid_i && !inv_all_i;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    brtgt_way #(
      .SETS  (SETS),
      .TAG_W (TAG_W),
      .INSN_W(INSN_W)
    ) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (inv_all_i),
      .wr_en_i    (fill_we_w && fill_way_w[w]),
      .wr_idx_i   (fill_idx_w),
      .wr_tag_i   (fill_tag_w),
      .wr_insn0_i (fill_insn0_i),
      .wr_insn1_i (fill_insn1_i),
      .ra_idx_i   (lk_idx_w),
      .ra_valid_o (ra_valid_w[w]),
      .ra_tag_o   (ra_tag_w[w]),
      .ra_insn0_o (ra_insn0_w[w]),
      .ra_insn1_o (ra_insn1_w[w]),
      .rb_idx_i   (fill_idx_w),
      .rb_valid_o (rb_valid_w[w]),
      .rb_tag_o   (rb_tag_w[w]),
      .any_valid_o(any_valid_vec_w[w])
    );
    assign lk_match_w[w]   = ra_valid_w[w] && (ra_tag_w[w] == lk_tag_w);
    assign fill_match_w[w] = rb_valid_w[w] && (rb_tag_w[w] == fill_tag_w);
  end

  assign any_valid_w = |any_valid_vec_w;
  assign lk_hit_w    = lk_valid_i && enable_i && !inv_all_i && (|lk_match_w);

  always_comb begin
    sel_insn0_w = '0;
    sel_insn1_w = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (lk_match_w[w]) begin
        sel_insn0_w = sel_insn0_w | ra_insn0_w[w];
        sel_insn1_w = sel_insn1_w | ra_insn1_w[w];
      end
    end
  end

  brtgt_repl #(
    .SETS(SETS)
  ) u_repl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_en_i   (fill_we_w),
    .fill_idx_i  (fill_idx_w),
    .fill_valid_i(rb_valid_w),
    .fill_match_i(fill_match_w),
    .fill_way_o  (fill_way_w),
    .touch_en_i  (lk_hit_w),
    .touch_idx_i (lk_idx_w),
    .touch_way_i (way_enc(lk_match_w))
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o       <= 1'b0;
      hit_insn0_o <= '0;
      hit_insn1_o <= '0;
    end else begin
      hit_o       <= lk_hit_w;
      hit_insn0_o <= lk_hit_w ? sel_insn0_w : '0;
      hit_insn1_o <= lk_hit_w ? sel_insn1_w : '0;
    end
  end

  // R4: disabled cycles never produce a hit
  p_disabled_no_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !hit_o);

  // R3: a hit answers a lookup from the previous cycle
  p_hit_needs_lookup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(lk_valid_i));

  // R3: a miss drives zeros on both instruction outputs
  p_miss_zero_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_insn0_o == '0 && hit_insn1_o == '0));

  // R6: a fill colliding with invalidate leaves the array empty
  p_inv_drops_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && fill_valid_i) |=> !any_valid_w);

  // R7: a tag is held by at most one way of a set
  p_single_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match_w));

endmodule

// File: tb/brtgt_cache_bench.sv
module brtgt_cache_bench;

  localparam int AW  = 12;
  localparam int IW  = 16;
  localparam int NS  = 4;
  localparam int IXW = 2;
  localparam int TW  = AW - IXW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1, inv = 1'b0, lv = 1'b0, fv = 1'b0;
  logic [AW-1:0] la = '0, fa = '0;
  logic [IW-1:0] d0 = '0, d1 = '0;
  logic          hit;
  logic [IW-1:0] q0, q1;

  int checks = 0;
  int errors = 0;

  brtgt_cache #(.ADDR_W(AW), .INSN_W(IW), .SETS(NS)) u_brtgt_cache (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .inv_all_i(inv),
    .lk_valid_i(lv), .lk_addr_i(la), .fill_valid_i(fv), .fill_addr_i(fa),
    .fill_insn0_i(d0), .fill_insn1_i(d1),
    .hit_o(hit), .hit_insn0_o(q0), .hit_insn1_o(q1)
  );

  always #4 clk = ~clk;

  // bench model
  bit          m_v    [NS][4];
  int          m_tag  [NS][4];
  int          m_d0   [NS][4];
  int          m_d1   [NS][4];
  bit          m_root [NS];
  bit          m_left [NS];
  bit          m_right[NS];

  function automatic logic [AW-1:0] mk(input int tag, input int set, input int low);
    return AW'(tag * (NS * 4) + set * 4 + (low % 4));
  endfunction

  function automatic int m_victim(input int s);
    return m_root[s] ? 2 + int'(m_right[s]) : int'(m_left[s]);
  endfunction

  task automatic m_touch(input int s, input int w);
    m_root[s] = (w < 2);
    if (w < 2) m_left[s] = (w == 0);
    else       m_right[s] = (w == 2);
  endtask

  task automatic check(input string req, input bit eh, input int e0, input int e1);
    checks++;
    if (hit !== eh || int'(q0) != e0 || int'(q1) != e1) begin
      errors++;
      $display("FAIL %s: got hit=%0b d0=%h d1=%h, expected hit=%0b d0=%h d1=%h",
               req, hit, q0, q1, eh, e0[IW-1:0], e1[IW-1:0]);
    end
  endtask

  task automatic step(input string req, input bit l_v, input logic [AW-1:0] l_a,
                      input bit f_v, input logic [AW-1:0] f_a, input int f0, input int f1,
                      input bit i_v, input bit e_v);
    int ls, lt, fs, ft, hw, fw;
    bit eh;
    int e0, e1;
    ls = (int'(l_a) / 4) % NS;  lt = int'(l_a) / (4 * NS);
    fs = (int'(f_a) / 4) % NS;  ft = int'(f_a) / (4 * NS);
    eh = 0; e0 = 0; e1 = 0; hw = 0;
    if (l_v && e_v && !i_v)
      for (int w = 0; w < 4; w++)
        if (m_v[ls][w] && m_tag[ls][w] == lt) begin
          eh = 1; e0 = m_d0[ls][w]; e1 = m_d1[ls][w]; hw = w;
        end
    if (f_v && !i_v) begin
      fw = -1;
      for (int w = 0; w < 4; w++) if (m_v[fs][w] && m_tag[fs][w] == ft) fw = w;
      if (fw < 0) for (int w = 3; w >= 0; w--) if (!m_v[fs][w]) fw = w;
      if (fw < 0) fw = m_victim(fs);
      m_v[fs][fw] = 1; m_tag[fs][fw] = ft; m_d0[fs][fw] = f0; m_d1[fs][fw] = f1;
      m_touch(fs, fw);
    end
    if (eh && !(f_v && !i_v && fs == ls)) m_touch(ls, hw);
    if (i_v) for (int s = 0; s < NS; s++) for (int w = 0; w < 4; w++) m_v[s][w] = 0;
    lv = l_v; la = l_a; fv = f_v; fa = f_a; d0 = IW'(f0); d1 = IW'(f1); inv = i_v; en = e_v;
    @(negedge clk);
    check(req, eh, e0, e1);
    lv = 0; fv = 0; inv = 0;
  endtask

  task automatic fill(input string req, input int tag, input int s, input int f0, input int f1);
    step(req, 0, '0, 1, mk(tag, s, tag), f0, f1, 0, 1);
  endtask

  task automatic look(input string req, input int tag, input int s, input int low);
    step(req, 1, mk(tag, s, low), 0, '0, 0, 0, 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_root[s] = 0; m_left[s] = 0; m_right[s] = 0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 0;
    end
    repeat (3) @(negedge clk);
    check("R11", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", 0, 0, 0);
    for (int s = 0; s < NS; s++) look("R11", 5, s, 0);

    // R10: fill every entry, then read all back with varying low bits (R2)
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 4; w++) fill("R10", w * 17 + 3, s, 16'h1000 + s * 16 + w, 16'h2000 + s * 16 + w);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 4; w++) look("R1", w * 17 + 3, s, w + s);
    for (int s = 0; s < NS; s++) look("R2", 200, s, 3);

    // R9: new tag in a full set evicts the pseudo-LRU victim
    fill("R9", 200, 1, 16'h3333, 16'h4444);
    for (int w = 0; w < 4; w++) look("R9", w * 17 + 3, 1, 1);
    look("R9", 200, 1, 2);

    // R7: refill of a present tag rewrites in place
    fill("R7", 37, 2, 16'h5555, 16'h6666);
    for (int w = 0; w < 4; w++) look("R7", w * 17 + 3, 2, 0);

    // R4: disabled lookups miss, contents survive
    for (int s = 0; s < NS; s++) step("R4", 1, mk(3, s, 0), 0, '0, 0, 0, 0, 0);
    for (int s = 0; s < NS; s++) look("R4", 3, s, 1);

    // R5: lookup in the invalidate cycle misses, then everything misses
    step("R5", 1, mk(3, 0, 0), 0, '0, 0, 0, 1, 1);
    for (int s = 0; s < NS; s++) look("R5", 20, s, 0);

    // R6: fill colliding with invalidate is dropped
    fill("R6", 9, 3, 16'h7777, 16'h8888);
    step("R6", 0, '0, 1, mk(11, 3, 0), 16'h9999, 16'haaaa, 1, 1);
    look("R6", 11, 3, 0);
    look("R6", 9, 3, 0);

    // R8: lowest free way first, then victim choice follows
    fill("R8", 1, 0, 16'h0101, 16'h0202);
    fill("R8", 2, 0, 16'h0303, 16'h0404);
    look("R8", 1, 0, 0);
    fill("R8", 3, 0, 16'h0505, 16'h0606);
    fill("R8", 4, 0, 16'h0707, 16'h0808);
    fill("R8", 5, 0, 16'h0909, 16'h0a0a);
    for (int t = 1; t <= 5; t++) look("R8", t, 0, t);

    // R9: long mixed sequence against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step("R9", r[0], mk(40 + (r[7:4] % 6), r[9:8] % NS, r[11:10]),
           r[1], mk(40 + (r[15:12] % 6), r[17:16] % NS, r[19:18]),
           r[31:16], r[15:0] ^ 16'h5a5a, (r[25:20] == 0), (r[29:26] != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule